// File: doc/BRIEF.md
# Write and Read Latency Scheduler for a DDR Controller Datapath

This block sits between the command issue logic of a custom DDR memory controller and the datapath interface of its physical layer. The physical layer reports a write latency and a read latency at runtime, each counted in controller clock cycles. For every write command, the block waits the write latency and then drives the data-strobe burst enable and the write-data-valid flag for one burst. For every read command, it opens a window at the read latency and checks that returned data arrives in that window with its valid flag.

The block is built for either full-rate or half-rate clocking. At half rate, each controller word carries two beats of data, and the returned valid flag has one bit for each half. A read can come back starting in the upper half of a word. The block re-packs such data so that every word it delivers begins with the first beat of the burst. The latency inputs are taken as given. They already include every delay on the path, so no other term is added.

Top module: `lat_sched`

## Requirements
- R1: Synchronous active-low reset clears all pending write and read state. It drives `dqs_burst_en`, `wdata_valid` and `rdata_valid` low and clears `lat_err` and `proto_err`.
- R2: A write command sampled in cycle t with an effective write latency W raises both `dqs_burst_en` and `wdata_valid` in cycles t+W through t+W+B-1, where B = BURST_LEN/2 at full rate and BURST_LEN/4 at half rate. Neither output is ever high without a matching write.
- R3: Each write command produces its own burst even while earlier writes are pending. Writes spaced exactly B cycles apart give one unbroken run of enable. Writes in consecutive cycles give a run that ends B-1 cycles after the last burst starts.
- R4: A write-latency input of 0 acts as 1. A value above MAX_WLAT acts as MAX_WLAT.
- R5: Returned data is presented on `rdata_out` with `rdata_valid` one cycle after the cycle that completes the word. At full rate that cycle is the one in which `phy_rvalid[0]` is high. At half rate with `phy_rvalid` = 2'b11 and no pending half, the word passes through unchanged.
- R6: At half rate (bit 0 = lower half, which holds the earlier beat), a return that starts with `phy_rvalid` = 2'b10 is held. Each later cycle with bit 0 set then yields the word {current lower half, held upper half}, with the held half in the low bits.
- R7: Both latency inputs are taken in only while no write or read is pending. Work already scheduled keeps its old latency. Any change to either input while work is pending sets the sticky `lat_err`.
- R8: A read command in cycle t opens a check window of B cycles (B+1 at half rate) that starts at cycle t+R. A return that starts in cycle t+R leaves `proto_err` low.
- R9: `proto_err` is sticky until reset. It is set when any `phy_rvalid` bit is high outside every open window, or when a window opens with all `phy_rvalid` bits low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Write command issued this cycle |
| rd_cmd | input | 1 | Read command issued this cycle |
| wlat_in | input | $clog2(MAX_WLAT+1) | Write latency reported by the physical layer |
| rlat_in | input | $clog2(MAX_RLAT+1) | Read latency reported by the physical layer |
| phy_rvalid | input | 2 at half rate, 1 at full rate | Read valid, one bit per half word |
| phy_rdata | input | DW | Read data word from the physical layer |
| dqs_burst_en | output | 1 | Data-strobe burst enable |
| wdata_valid | output | 1 | Write data valid |
| rdata_valid | output | 1 | Aligned read word valid |
| rdata_out | output | DW | Aligned read word |
| lat_err | output | 1 | Sticky: latency input changed while busy |
| proto_err | output | 1 | Sticky: read return outside or missing from its window |

## Verification
Two write bursts can overlap in the same cycle. The bench issues writes two cycles apart and in consecutive cycles. A queue of expected enable cycles then checks, every cycle, that the merged run has no gap and no extra cycle. Separately, a latency change can arrive in the same cycle that an earlier write is still counting down. The bench changes the write latency one cycle after issuing a write. It then confirms that the pending burst keeps its original slot, that `lat_err` rises, and that a write issued after the block goes idle uses the new value.

// File: rtl/lat_sched_pkg.sv
package lat_sched_pkg;
   // Beats moved per controller cycle: two at full rate (DDR), four at half rate.
   function automatic int unsigned beats_per_cycle(input bit half_rate);
      return half_rate ? 4 : 2;
   endfunction

   // Controller cycles needed to move one burst.
   function automatic int unsigned burst_cycles(input int unsigned burst_len, input bit half_rate);
      return burst_len / beats_per_cycle(half_rate);
   endfunction
endpackage

// File: rtl/lat_sched_timer.sv
// Latency timer: one slot per cycle of delay, plus a run counter for the burst.
module lat_sched_timer #(
   parameter int MAXL = 16,
   parameter int RUN  = 2,
   localparam int LW  = $clog2(MAXL + 1),
   localparam int CW  = $clog2(RUN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [LW-1:0] lat,
   output logic          start,
   output logic          active,
   output logic          busy
);
   logic [MAXL-1:0] slot_q, slot_d;
   logic [CW-1:0]   run_q;
   logic [LW-1:0]   lat_c;

   // Clamp latency into 1..MAXL.
   always_comb begin
      lat_c = lat;
      if (lat == '0)
         lat_c = LW'(1);
      else if (lat > LW'(MAXL))
         lat_c = LW'(MAXL);
   end

   always_comb begin
      slot_d = slot_q >> 1;
      if (fire)
         slot_d = slot_d | ({{(MAXL-1){1'b0}}, 1'b1} << (lat_c - LW'(1)));
   end

   assign start  = slot_q[0];
   assign active = start | (run_q != '0);
   assign busy   = (slot_q != '0) | (run_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         run_q  <= '0;
      end else begin
         slot_q <= slot_d;
         if (start)
            run_q <= CW'(RUN - 1);
         else if (run_q != '0)
            run_q <= run_q - CW'(1);
      end
   end
endmodule

// File: rtl/lat_sched_align.sv
// Read word assembly: pass-through at full rate, half-word realignment at half rate.
module lat_sched_align #(
   parameter int DW        = 16,
   parameter bit HALF_RATE = 1'b1,
   localparam int VW       = HALF_RATE ? 2 : 1,
   localparam int HW       = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] rv,
   input  logic [DW-1:0] rdata,
   output logic          out_v,
   output logic [DW-1:0] out_d
);
   generate
      if (HALF_RATE) begin : g_half
         logic          hold_v;
         logic [HW-1:0] hold_d;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_v <= 1'b0;
               hold_d <= '0;
               out_v  <= 1'b0;
               out_d  <= '0;
            end else if (hold_v) begin
               out_v <= rv[0];
               if (rv[0])
                  out_d <= {rdata[HW-1:0], hold_d};
               hold_v <= rv[1];
               if (rv[1])
                  hold_d <= rdata[DW-1:HW];
            end else begin
               out_v  <= (rv == 2'b11);
               if (rv == 2'b11)
                  out_d <= rdata;
               hold_v <= (rv == 2'b10);
               if (rv == 2'b10)
                  hold_d <= rdata[DW-1:HW];
            end
         end
      end else begin : g_full
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_v <= 1'b0;
               out_d <= '0;
            end else begin
               out_v <= rv[0];
               if (rv[0])
                  out_d <= rdata;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lat_sched.sv
module lat_sched #(
   parameter bit HALF_RATE = 1'b1,
   parameter int DW        = 16,
   parameter int BURST_LEN = 8,
   parameter int MAX_WLAT  = 16,
   parameter int MAX_RLAT  = 16,
   localparam int VW       = HALF_RATE ? 2 : 1,
   localparam int WLW      = $clog2(MAX_WLAT + 1),
   localparam int RLW      = $clog2(MAX_RLAT + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_cmd,
   input  logic           rd_cmd,
   input  logic [WLW-1:0] wlat_in,
   input  logic [RLW-1:0] rlat_in,
   input  logic [VW-1:0]  phy_rvalid,
   input  logic [DW-1:0]  phy_rdata,
   output logic           dqs_burst_en,
   output logic           wdata_valid,
   output logic           rdata_valid,
   output logic [DW-1:0]  rdata_out,
   output logic           lat_err,
   output logic           proto_err
);
   import lat_sched_pkg::*;

   localparam int BEATS = int'(burst_cycles(BURST_LEN, HALF_RATE));
   localparam int RWIN  = BEATS + (HALF_RATE ? 1 : 0);

   generate
      if (BURST_LEN % int'(beats_per_cycle(HALF_RATE)) != 0) begin : g_bad_bl
         $error("lat_sched: BURST_LEN must fill whole controller cycles");
      end
      if (DW % 2 != 0) begin : g_bad_dw
         $error("lat_sched: DW must be even");
      end
      if (MAX_WLAT < 2 || MAX_RLAT < 2) begin : g_bad_lat
         $error("lat_sched: latency ranges must be at least 2");
      end
   endgenerate

   logic           w_active, w_busy, w_start_unused;
   logic           r_start, r_active, r_busy;
   logic           idle;
   logic [WLW-1:0] wlat_q, wlat_eff;
   logic [RLW-1:0] rlat_q, rlat_eff;
   logic           rv_any;

   assign idle     = !w_busy && !r_busy;
   assign wlat_eff = idle ? wlat_in : wlat_q;
   assign rlat_eff = idle ? rlat_in : rlat_q;
   assign rv_any   = |phy_rvalid;

   lat_sched_timer #(.MAXL(MAX_WLAT), .RUN(BEATS)) u_wr_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (wr_cmd),
      .lat    (wlat_eff),
      .start  (w_start_unused),
      .active (w_active),
      .busy   (w_busy)
   );

   lat_sched_timer #(.MAXL(MAX_RLAT), .RUN(RWIN)) u_rd_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (rd_cmd),
      .lat    (rlat_eff),
      .start  (r_start),
      .active (r_active),
      .busy   (r_busy)
   );

   lat_sched_align #(.DW(DW), .HALF_RATE(HALF_RATE)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .rv    (phy_rvalid),
      .rdata (phy_rdata),
      .out_v (rdata_valid),
      .out_d (rdata_out)
   );

   assign dqs_burst_en = w_active;
   assign wdata_valid  = w_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wlat_q    <= '0;
         rlat_q    <= '0;
         lat_err   <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         if (idle) begin
            wlat_q <= wlat_in;
            rlat_q <= rlat_in;
         end else if (wlat_in != wlat_q || rlat_in != rlat_q) begin
            lat_err <= 1'b1;
         end
         if ((rv_any && !r_active) || (r_start && !rv_any))
            proto_err <= 1'b1;
      end
   end
endmodule

// File: rtl/lat_sched_chk.sv
module lat_sched_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_cmd,
   input logic rv_lo,
   input logic dqs_burst_en,
   input logic wdata_valid,
   input logic rdata_valid,
   input logic lat_err,
   input logic proto_err
);
   logic wr_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)
         wr_seen <= 1'b0;
      else if (wr_cmd)
         wr_seen <= 1'b1;
   end

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!dqs_burst_en && !wdata_valid && !rdata_valid && !lat_err && !proto_err));

   // R2
   a_r2_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dqs_burst_en || wdata_valid) |-> wr_seen);

   // R5
   a_r5_word_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |-> $past(rv_lo));

   // R7
   a_r7_lat_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lat_err |=> lat_err);

   // R9
   a_r9_proto_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
endmodule

bind lat_sched lat_sched_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_cmd       (wr_cmd),
   .rv_lo        (phy_rvalid[0]),
   .dqs_burst_en (dqs_burst_en),
   .wdata_valid  (wdata_valid),
   .rdata_valid  (rdata_valid),
   .lat_err      (lat_err),
   .proto_err    (proto_err)
);

// File: tb/tb_lat_sched.sv
`timescale 1ns/1ps
module tb_lat_sched;
   typedef struct {int c; logic [15:0] d;} rexp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_cmd = 1'b0, rd_cmd = 1'b0;
   logic [4:0]  wlat = 5'd4, rlat = 5'd9;
   logic [1:0]  rv = 2'b00;
   logic [15:0] rd = '0;
   int          cyc = 0;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   logic        h_bst, h_wdv, h_rv, h_le, h_pe;
   logic [15:0] h_rd;
   logic        f_bst, f_wdv, f_rv, f_le, f_pe;
   logic [15:0] f_rd;

   int    expw_h[$], expw_f[$];
   rexp_t expr_h[$], expr_f[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lat_sched dut (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
      .wlat_in(wlat), .rlat_in(rlat), .phy_rvalid(rv), .phy_rdata(rd),
      .dqs_burst_en(h_bst), .wdata_valid(h_wdv), .rdata_valid(h_rv),
      .rdata_out(h_rd), .lat_err(h_le), .proto_err(h_pe));

   lat_sched #(.HALF_RATE(1'b0)) dut_f (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
      .wlat_in(wlat), .rlat_in(rlat), .phy_rvalid(rv[0]), .phy_rdata(rd),
      .dqs_burst_en(f_bst), .wdata_valid(f_wdv), .rdata_valid(f_rv),
      .rdata_out(f_rd), .lat_err(f_le), .proto_err(f_pe));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
      end
   endtask

   task automatic next();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) next();
   endtask

   // Driver: issue one write and push the expected enable cycles of both variants.
   task automatic wr(input int w_eff, input int w_in);
      wlat = 5'(w_in);
      wr_cmd = 1'b1;
      for (int k = 0; k < 2; k++)
         if (expw_h.size() == 0 || expw_h[$] < cyc + w_eff + k) expw_h.push_back(cyc + w_eff + k);
      for (int k = 0; k < 4; k++)
         if (expw_f.size() == 0 || expw_f[$] < cyc + w_eff + k) expw_f.push_back(cyc + w_eff + k);
      next();
      wr_cmd = 1'b0;
   endtask

   task automatic rd_issue(input int r, output int c);
      c = cyc;
      rlat = 5'(r);
      rd_cmd = 1'b1;
      next();
      rd_cmd = 1'b0;
      while (cyc < c + r) next();
   endtask

   task automatic rd_aligned(input int r, input logic [15:0] a, input logic [15:0] b);
      int c;
      rd_issue(r, c);
      rv = 2'b11; rd = a;
      expr_h.push_back('{c + r + 1, a}); expr_f.push_back('{c + r + 1, a});
      next();
      rd = b;
      expr_h.push_back('{c + r + 2, b}); expr_f.push_back('{c + r + 2, b});
      next();
      rv = 2'b00; rd = '0;
   endtask

   task automatic rd_unaligned(input int r, input logic [7:0] h0, input logic [7:0] l1,
                               input logic [7:0] h1, input logic [7:0] l2);
      int c;
      rd_issue(r, c);
      rv = 2'b10; rd = {h0, 8'h00};
      next();
      rv = 2'b11; rd = {h1, l1};
      expr_h.push_back('{c + r + 2, {l1, h0}}); expr_f.push_back('{c + r + 2, {h1, l1}});
      next();
      rv = 2'b01; rd = {8'h00, l2};
      expr_h.push_back('{c + r + 3, {l2, h1}}); expr_f.push_back('{c + r + 3, {8'h00, l2}});
      next();
      rv = 2'b00; rd = '0;
   endtask

   // Monitor: pops the scoreboard queues as results appear.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         while (expw_h.size() > 0 && expw_h[0] < cyc) begin
            chk(1'b0, "R2", "half-rate burst cycle missed", 32'(expw_h[0]), 32'(cyc));
            void'(expw_h.pop_front());
         end
         if (expw_h.size() > 0 && expw_h[0] == cyc) begin
            void'(expw_h.pop_front());
            chk(h_bst && h_wdv, "R2", "half-rate burst enable", {30'b0, h_bst, h_wdv}, 32'h3);
         end else if (h_bst || h_wdv) begin
            chk(1'b0, "R3", "half-rate enable without pending burst", {30'b0, h_bst, h_wdv}, 32'h0);
         end
         while (expw_f.size() > 0 && expw_f[0] < cyc) begin
            chk(1'b0, "R2", "full-rate burst cycle missed", 32'(expw_f[0]), 32'(cyc));
            void'(expw_f.pop_front());
         end
         if (expw_f.size() > 0 && expw_f[0] == cyc) begin
            void'(expw_f.pop_front());
            chk(f_bst && f_wdv, "R2", "full-rate burst enable", {30'b0, f_bst, f_wdv}, 32'h3);
         end else if (f_bst || f_wdv) begin
            chk(1'b0, "R3", "full-rate enable without pending burst", {30'b0, f_bst, f_wdv}, 32'h0);
         end
         if (h_rv) begin
            if (expr_h.size() == 0)
               chk(1'b0, "R6", "half-rate unexpected read word", {16'h0, h_rd}, 32'h0);
            else begin
               chk(expr_h[0].c == cyc && expr_h[0].d == h_rd, "R6", "half-rate read word",
                   {16'h0, h_rd}, {16'h0, expr_h[0].d});
               void'(expr_h.pop_front());
            end
         end else if (expr_h.size() > 0 && expr_h[0].c <= cyc) begin
            chk(1'b0, "R5", "half-rate read word missing", 32'(cyc), 32'(expr_h[0].c));
            void'(expr_h.pop_front());
         end
         if (f_rv) begin
            if (expr_f.size() == 0)
               chk(1'b0, "R5", "full-rate unexpected read word", {16'h0, f_rd}, 32'h0);
            else begin
               chk(expr_f[0].c == cyc && expr_f[0].d == f_rd, "R5", "full-rate read word",
                   {16'h0, f_rd}, {16'h0, expr_f[0].d});
               void'(expr_f.pop_front());
            end
         end else if (expr_f.size() > 0 && expr_f[0].c <= cyc) begin
            chk(1'b0, "R5", "full-rate read word missing", 32'(cyc), 32'(expr_f[0].c));
            void'(expr_f.pop_front());
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 32'(cyc), 32'h0);
      finish_run();
   end

   initial begin
      idle(3);
      // R1: outputs quiet under reset
      chk(!h_bst && !h_wdv && !h_rv && !h_le && !h_pe, "R1", "reset state",
          {27'b0, h_bst, h_wdv, h_rv, h_le, h_pe}, 32'h0);
      rst_n = 1'b1;
      next();

      // R2: single write, latency 5
      wr(5, 5);
      idle(10);
      // R4: latency 0 acts as 1
      wr(1, 0);
      idle(6);
      // R2/R4: latency at maximum, then above maximum
      wlat = 5'd16; next();
      wr(16, 16);
      idle(22);
      wlat = 5'd20; next();
      wr(16, 20);
      idle(22);

      // R3: writes two cycles apart, then in consecutive cycles
      wlat = 5'd3; next();
      wr(3, 3); next(); wr(3, 3);
      idle(10);
      wr(3, 3); wr(3, 3);
      idle(10);

      // R5/R8: aligned return at read latency 9
      rd_aligned(9, 16'hA1B2, 16'hC3D4);
      idle(5);
      chk(!h_pe, "R8", "proto_err after aligned return", {31'b0, h_pe}, 32'h0);
      // R6/R8: unaligned return at read latency 4
      rd_unaligned(4, 8'h11, 8'h22, 8'h33, 8'h44);
      idle(5);
      chk(!h_pe, "R8", "proto_err after unaligned return", {31'b0, h_pe}, 32'h0);
      chk(!h_le, "R7", "no latency error while inputs held", {31'b0, h_le}, 32'h0);

      // R7: latency change while a write is pending
      wlat = 5'd6; next();
      wr(6, 6);
      wlat = 5'd2; next();
      chk(h_le, "R7", "lat_err after change while busy", {31'b0, h_le}, 32'h1);
      idle(10);
      wr(2, 2);
      idle(6);
      chk(h_le, "R7", "lat_err stays set", {31'b0, h_le}, 32'h1);

      // R9: stray valid with nothing outstanding
      chk(!h_pe, "R9", "proto_err clear before stray valid", {31'b0, h_pe}, 32'h0);
      rv = 2'b01; rd = 16'h5A5A;
      expr_f.push_back('{cyc + 1, 16'h5A5A});
      next();
      rv = 2'b00; rd = '0;
      chk(h_pe, "R9", "proto_err after stray valid", {31'b0, h_pe}, 32'h1);
      idle(3);
      chk(h_pe, "R9", "proto_err sticky", {31'b0, h_pe}, 32'h1);

      // R1: reset clears the sticky errors
      rst_n = 1'b0;
      idle(2);
      chk(!h_le && !h_pe && !h_bst && !h_rv, "R1", "errors cleared by reset",
          {28'b0, h_le, h_pe, h_bst, h_rv}, 32'h0);
      rst_n = 1'b1;
      next();

      // R9: read that never returns
      begin
         int c;
         rd_issue(4, c);
      end
      idle(3);
      chk(h_pe, "R9", "proto_err after missing return", {31'b0, h_pe}, 32'h1);

      idle(4);
      chk(expw_h.size() == 0 && expw_f.size() == 0, "R2", "all bursts seen",
          32'(expw_h.size() + expw_f.size()), 32'h0);
      chk(expr_h.size() == 0 && expr_f.size() == 0, "R5", "all read words seen",
          32'(expr_h.size() + expr_f.size()), 32'h0);
      finish_run();
   end
endmodule